// File: doc/BRIEF.md
# Dual-Clock Serial Line Memory

A line store of 5,048 eight-bit words with a write side and a read side. Each side runs on its own clock and walks through the array with its own address pointer, one step per enabled edge. Neither side uses explicit addresses. A clear strobe on each side sends that side's pointer back to word 0, so the host only frames lines with strobes.

Two uses follow from this. As a fixed delay line, both sides share one clock and the read side is cleared a chosen number of cycles after the write side, so the pointer offset becomes the delay. As a rate converter, the read clock runs faster than the write clock and the read side walks through a stored line more than once.

A single-bit flag reports reads that land on a word the write side is storing, or has just stored. Data returned by such a read is not defined. The two clocks are assumed to come from one source, so the flag's comparison across the sides is meaningful.

Top module: `line_mem_buffer`

## Requirements
- R1: On a write-clock edge with `we_i`=1 and `wrst_i`=0, `wdata_i` is stored at the write pointer and the pointer advances by one. From word 5,047 it advances to word 0.
- R2: On a read-clock edge with `re_i`=1 and `rrst_i`=0, the word at the read pointer appears on `rdata_o` after that edge and the read pointer advances with the same wrap from 5,047 to 0.
- R3: On a read-clock edge with `re_i`=0, `rdata_o` keeps its value, and the read pointer keeps its value unless `rrst_i` is high.
- R4: A write-clock edge with `wrst_i`=1 and `we_i`=0 sets the write pointer to 0 and stores nothing. The next enabled write goes to word 0.
- R5: A read-clock edge with `rrst_i`=1 and `re_i`=0 sets the read pointer to 0 and leaves `rdata_o` unchanged. The next enabled read returns word 0.
- R6: When a clear strobe and the enable of the same side are both high on an edge, the access uses word 0 and the pointer then stands at word 1. This holds for both sides.
- R7: Consider a common clock with both enables held high, `wrst_i` strobed at edge k and `rrst_i` strobed at edge k+n. From edge k+n onwards, the `rdata_o` seen after edge j equals the `wdata_i` written at edge j-n.
- R8: After each read-clock edge, `collide_o` is 1 exactly when `re_i` was high and the read address matched either the write address in use at that moment (with `we_i` high) or the address stored at the most recent write edge (if that edge had `we_i` high). Otherwise `collide_o` is 0, and it is always 0 after an edge with `re_i`=0.
- R9: With the read clock at twice the write rate, a line stored by the write side can be read twice in succession: the read pointer wraps and returns every word once per pass.
- R10: While `rst_ni` is low, `rdata_o` and `collide_o` are 0 and both pointers are at word 0. After release, an enabled write and an enabled read with no clear strobes use word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Write-side clock |
| we_i | input | 1 | Write enable |
| wrst_i | input | 1 | Write pointer clear strobe |
| wdata_i | input | 8 | Write data |
| rclk_i | input | 1 | Read-side clock |
| re_i | input | 1 | Read enable |
| rrst_i | input | 1 | Read pointer clear strobe |
| rdata_o | output | 8 | Registered read data |
| collide_o | output | 1 | Read hit a word being or just written |

## Verification
The bound checker follows each pointer on every edge of its own clock. It checks the step with wrap, the hold, the clear with and without the enable, that the output holds while reads are idle, and that the collision flag is low after idle reads. Data integrity needs the scenarios: stored words are compared against a bench model. This covers a write line plus a wrapped overwrite, clears placed between accesses, a three-cycle delay line, collision offsets of zero, one and two, and a twice-rate double read of a full line.

// File: rtl/lmb_pkg.sv
package lmb_pkg;
  localparam int unsigned LMB_DEPTH = 5048;
  localparam int unsigned LMB_DW    = 8;

  // pointer action, encoded {clear, enable}
  typedef enum logic [1:0] {
    PTR_HOLD     = 2'd0,
    PTR_STEP     = 2'd1,
    PTR_CLR      = 2'd2,
    PTR_CLR_STEP = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/lmb_ptr.sv
module lmb_ptr
  import lmb_pkg::*;
#(
  parameter  int unsigned DEPTH = LMB_DEPTH,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;
  ptr_op_e       op;

  assign op     = ptr_op_e'({clr_i, en_i});
  // a clear redirects the access of this very edge to word 0
  assign addr_o = clr_i ? '0 : ptr_q;

  always_comb begin
    case (op)
      PTR_HOLD:     ptr_d = ptr_q;
      PTR_STEP:     ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      PTR_CLR:      ptr_d = '0;
      PTR_CLR_STEP: ptr_d = AW'(1);
      default:      ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/lmb_array.sv
module lmb_array
  import lmb_pkg::*;
#(
  parameter  int unsigned DEPTH = LMB_DEPTH,
  parameter  int unsigned DW    = LMB_DW,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          rst_ni,
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/lmb_collide.sv
module lmb_collide #(
  parameter int unsigned AW = 13
) (
  input  logic          rst_ni,
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic          collide_o
);
  logic [AW-1:0] last_addr_q;
  logic          last_vld_q;
  logic          hit_now, hit_last;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_q <= '0;
      last_vld_q  <= 1'b0;
    end else begin
      last_vld_q <= we_i;
      if (we_i) last_addr_q <= waddr_i;
    end
  end

  // clocks are related; write-side state is sampled directly
  assign hit_now  = we_i && (raddr_i == waddr_i);
  assign hit_last = last_vld_q && (raddr_i == last_addr_q);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) collide_o <= 1'b0;
    else         collide_o <= re_i && (hit_now || hit_last);
  end
endmodule

// File: rtl/line_mem_buffer.sv
module line_mem_buffer
  import lmb_pkg::*;
#(
  parameter  int unsigned DEPTH = LMB_DEPTH,
  parameter  int unsigned DW    = LMB_DW,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          rst_ni,
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic          wrst_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic          rrst_i,
  output logic [DW-1:0] rdata_o,
  output logic          collide_o
);
  logic [AW-1:0] waddr, raddr;

  lmb_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .en_i   (we_i),
    .clr_i  (wrst_i),
    .addr_o (waddr)
  );

  lmb_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .en_i   (re_i),
    .clr_i  (rrst_i),
    .addr_o (raddr)
  );

  lmb_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
    .rst_ni  (rst_ni),
    .wclk_i  (wclk_i),
    .we_i    (we_i),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .rclk_i  (rclk_i),
    .re_i    (re_i),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );

  lmb_collide #(.AW(AW)) u_collide (
    .rst_ni    (rst_ni),
    .wclk_i    (wclk_i),
    .we_i      (we_i),
    .waddr_i   (waddr),
    .rclk_i    (rclk_i),
    .re_i      (re_i),
    .raddr_i   (raddr),
    .collide_o (collide_o)
  );
endmodule

// File: rtl/lmb_checker.sv
module lmb_checker #(
  parameter  int unsigned DEPTH = 5048,
  parameter  int unsigned DW    = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input logic          rst_ni,
  input logic          wclk_i,
  input logic          we_i,
  input logic          wrst_i,
  input logic          rclk_i,
  input logic          re_i,
  input logic          rrst_i,
  input logic [DW-1:0] rdata_o,
  input logic          collide_o,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] raddr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  AST_WPTR_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (we_i && !wrst_i) |=> (wrst_i || waddr == nxt($past(waddr)))); // R1
  AST_WPTR_HOLD: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!we_i && !wrst_i) |=> (wrst_i || waddr == $past(waddr))); // R1
  AST_WPTR_RANGE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    waddr <= LAST); // R1
  AST_RPTR_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (re_i && !rrst_i) |=> (rrst_i || raddr == nxt($past(raddr)))); // R2
  AST_RD_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R3
  AST_RPTR_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!re_i && !rrst_i) |=> (rrst_i || raddr == $past(raddr))); // R3
  AST_WPTR_CLR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wrst_i && !we_i) |=> (wrst_i || waddr == '0)); // R4
  AST_RPTR_CLR: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rrst_i && !re_i) |=> (rrst_i || raddr == '0)); // R5
  AST_WPTR_CLR_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wrst_i && we_i) |=> (wrst_i || waddr == AW'(1))); // R6
  AST_RPTR_CLR_STEP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rrst_i && re_i) |=> (rrst_i || raddr == AW'(1))); // R6
  AST_NO_COLL_IDLE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re_i |=> !collide_o); // R8
endmodule

bind line_mem_buffer lmb_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .rst_ni    (rst_ni),
  .wclk_i    (wclk_i),
  .we_i      (we_i),
  .wrst_i    (wrst_i),
  .rclk_i    (rclk_i),
  .re_i      (re_i),
  .rrst_i    (rrst_i),
  .rdata_o   (rdata_o),
  .collide_o (collide_o),
  .waddr     (waddr),
  .raddr     (raddr)
);

// File: tb/line_mem_buffer_bench.sv
`timescale 1ns/1ps
module line_mem_buffer_bench;
  localparam int DEPTH = 5048;

  logic clk = 1'b0, clkh = 1'b0, half_mode = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0, wrst = 1'b0, re = 1'b0, rrst = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       collide;
  logic       wclk, rclk;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) clkh <= ~clkh;
  assign rclk = clk;
  assign wclk = half_mode ? clkh : clk;

  line_mem_buffer #(.DEPTH(DEPTH), .DW(8)) u_line_mem_buffer (
    .rst_ni    (rst_ni),
    .wclk_i    (wclk),
    .we_i      (we),
    .wrst_i    (wrst),
    .wdata_i   (wdata),
    .rclk_i    (rclk),
    .re_i      (re),
    .rrst_i    (rrst),
    .rdata_o   (rdata),
    .collide_o (collide)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wtick();
    @(posedge wclk); #1;
  endtask

  function automatic logic [7:0] pat(input int i, input int salt);
    return 8'((i * 7 + salt) ^ (i / 256));
  endfunction

  task automatic idle();
    we = 0; wrst = 0; re = 0; rrst = 0; tick();
  endtask

  task automatic t_reset();
    rst_ni = 0; #12;
    chk("R10 rdata in reset", rdata, 0);
    chk("R10 collide in reset", collide, 0);
    @(negedge clk); rst_ni = 1; tick();
    we = 1; wdata = 8'h5A; tick();
    we = 0; tick();
    re = 1; tick();
    chk("R10 first read after reset", rdata, 8'h5A);
    re = 0; tick();
  endtask

  task automatic t_basic();
    wrst = 1; we = 1; wdata = pat(0, 1); tick();
    wrst = 0;
    for (int i = 1; i < 8; i++) begin wdata = pat(i, 1); tick(); end
    we = 0; tick();
    rrst = 1; re = 1; tick();
    rrst = 0;
    chk("R6 read with clear returns word 0", rdata, pat(0, 1));
    for (int i = 1; i < 8; i++) begin
      tick();
      chk("R1 R2 sequential word", rdata, pat(i, 1));
    end
    re = 0; tick();
  endtask

  task automatic t_hold();
    rrst = 1; re = 1; tick();
    rrst = 0; tick();
    re = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R3 output held while idle", rdata, pat(1, 1));
    end
    re = 1; tick();
    chk("R3 pointer held while idle", rdata, pat(2, 1));
    re = 0; tick();
  endtask

  task automatic t_wreset();
    wrst = 1; we = 1; wdata = pat(0, 2); tick();
    wrst = 0; wdata = pat(1, 2); tick();
    wdata = pat(2, 2); tick();
    we = 0; wrst = 1; tick();
    wrst = 0; we = 1; wdata = 8'hC0; tick();
    wdata = 8'hC1; tick();
    we = 0; tick();
    rrst = 1; re = 1; tick();
    rrst = 0;
    chk("R4 write after clear lands on word 0", rdata, 8'hC0);
    tick(); chk("R4 second write lands on word 1", rdata, 8'hC1);
    tick(); chk("R4 word 2 untouched", rdata, pat(2, 2));
    re = 0; tick();
  endtask

  task automatic t_rreset();
    rrst = 1; re = 1; tick();
    rrst = 0; tick();
    chk("R5 setup read", rdata, 8'hC1);
    rrst = 1; re = 0; tick();
    chk("R5 clear without enable keeps output", rdata, 8'hC1);
    rrst = 0; re = 1; tick();
    chk("R5 next read returns word 0", rdata, 8'hC0);
    re = 0; tick();
  endtask

  task automatic t_wrap();
    wrst = 1; we = 1;
    for (int i = 0; i < DEPTH + 2; i++) begin
      wdata = (i < DEPTH) ? pat(i, 3) : pat(i, 4);
      tick();
      wrst = 0;
    end
    we = 0; tick();
    rrst = 1; re = 1;
    for (int i = 0; i < DEPTH + 2; i++) begin
      int a;
      logic [7:0] e;
      tick();
      rrst = 0;
      a = i % DEPTH;
      e = (a < 2) ? pat(DEPTH + a, 4) : pat(a, 3);
      chk((i >= DEPTH) ? "R2 read wrap" : ((a < 2) ? "R1 write wrap" : "R1 full line"), rdata, e);
    end
    re = 0; tick();
  endtask

  task automatic t_delay();
    for (int e = 0; e < 40; e++) begin
      wrst = (e == 0); rrst = (e == 3); re = (e >= 3); we = 1;
      wdata = pat(e, 5);
      tick();
      if (e >= 3) begin
        chk("R7 delay of three", rdata, pat(e - 3, 5));
        chk("R8 no flag at offset three", collide, 0);
      end
    end
    idle();
  endtask

  task automatic t_coll();
    for (int n = 0; n < 3; n++) begin
      idle();
      for (int e = 0; e < 8; e++) begin
        wrst = (e == 0); rrst = (e == n); we = 1; re = (e >= n);
        wdata = pat(e, 7);
        tick();
        if (e >= n) chk("R8 flag versus offset", collide, (n < 2) ? 1 : 0);
      end
      rrst = 0; re = 0; we = 1; tick();
      chk("R8 flag clear on idle read", collide, 0);
    end
    idle();
  endtask

  task automatic t_double();
    idle();
    half_mode = 1;
    wtick();
    for (int i = 0; i < DEPTH; i++) begin
      wrst = (i == 0); we = 1; wdata = pat(i, 6);
      wtick();
    end
    wrst = 0; we = 0; wtick();
    rrst = 1; re = 1;
    for (int j = 0; j < 2 * DEPTH; j++) begin
      tick();
      rrst = 0;
      chk("R9 double read of line", rdata, pat(j % DEPTH, 6));
    end
    re = 0; tick();
    chk("R9 no flag on read-only pass", collide, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_wreset();
    t_rreset();
    t_wrap();
    t_delay();
    t_coll();
    t_double();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #750000;
    errs++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule